// File: doc/BRIEF.md
# Soft-Start and Hiccup Fault Sequencer

This block is the digital sequencer of a buck converter controller that governs start-up and overcurrent recovery. It waits until the charge-pump bias supply is reported good and the enable level is high. It then raises a reference code one step per clock over a fixed ramp period. That code clamps the regulation setpoint of the error amplifier, so the output rises in a controlled way. When the ramp completes, the code sits at full scale and a done flag is raised.

A pulsed overcurrent flag stops switching in the same cycle. The sequencer then runs a hiccup: three silent ramp periods with switching held off, followed by a real ramp from zero. If the fault persists, the next trip repeats the hiccup with no retry limit. Trips that arrive during the silent periods are ignored. A low enable level or a lost power-good flag returns the sequencer to its waiting state from any state.

The comparators, the error amplifier and the gate drivers are outside the block. They appear here only as input flags and the output code.

Top module: `softstart_hiccup_seq`

## Requirements
- R1: A clock edge with `rst_n` low puts the block in its waiting state. In that state `ref_code_o` = 0, `inhibit_o` = 1 and `done_o` = 0.
- R2: While `en_i` or `pgood_i` is low, no ramp starts. The outputs stay at their waiting values.
- R3: The first clock edge that sees `en_i` and `pgood_i` both high starts a ramp. In the cycle after that edge, `ref_code_o` is 0 and `inhibit_o` is 0. The code is unsigned binary and rises by one on each later edge.
- R4: A ramp lasts 2**CODE_W cycles (2048 by default). In the cycle after the code shows its all-ones value, `done_o` goes to 1. From then on, `ref_code_o` holds at all ones until a trip, a disable or a power loss.
- R5: `oc_trip_i` high during a ramp or steady state drives `inhibit_o` to 1 in that same cycle. From the next cycle, `ref_code_o` is 0 and `done_o` is 0.
- R6: After a trip, three silent ramp periods follow, 3 × 2**CODE_W cycles in all, with `inhibit_o` = 1 and `ref_code_o` = 0. A real ramp from code 0 then begins, as in R3.
- R7: `oc_trip_i` pulses during the silent periods have no effect. The silent window keeps its length.
- R8: A trip during the real ramp that follows a hiccup, or during steady state after it, starts a new full hiccup. Retries are unlimited.
- R9: `en_i` low drives `inhibit_o` to 1 in the same cycle. From the next cycle the block is in its waiting state. A later enable starts a fresh ramp from code 0.
- R10: `pgood_i` low acts as in R9 from any state, including the silent periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, one tick per switching cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable level, high to run |
| pgood_i | input | 1 | Bias supply above its power-on threshold (hysteresis applied upstream) |
| oc_trip_i | input | 1 | Overcurrent trip pulse from the current comparator |
| ref_code_o | output | CODE_W | Reference clamp code, unsigned binary |
| inhibit_o | output | 1 | High holds both power switches off |
| done_o | output | 1 | Start-up ramp complete, steady regulation |

## Verification
A wrong phase shows at once on `inhibit_o` and `ref_code_o`. A silent period taken as a ramp lets switching through, and a ramp taken as silent keeps the code at zero. An off-by-one in the ramp or silent counters becomes visible only at a period boundary. It shows as `done_o` rising one cycle early or late, or as the real ramp after a hiccup starting a cycle off. The reference model therefore compares every output on every cycle through complete ramps and complete hiccups, so each boundary is checked exactly. A trip pulse placed in the middle of the silent window shows whether it was wrongly accepted, because the window would then grow longer.

// File: rtl/shs_pkg.sv
// Shared types for the soft-start / hiccup sequencer.
// Assumes nothing beyond a 2-bit state encoding.
package shs_pkg;

    // Sequencer phases: waiting for power, real ramp, silent hiccup ramp, steady run
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RAMP  = 2'd1,
        SEQ_BLANK = 2'd2,
        SEQ_RUN   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/shs_counter.sv
// Modulo counter with a terminal flag.
// Counts 0..LIMIT-1 when stepped and wraps to zero after the last value.
// Clear has priority over step. Assumes LIMIT fits in W bits.
module shs_counter #(
    parameter int W     = 4,
    parameter int LIMIT = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    output logic [W-1:0] count_o,
    output logic         last_o
);

    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] count_q;

    // Count register: clear, wrap at LAST, or advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (step_i) begin
            if (count_q == LAST) begin
                count_q <= '0;
            end else begin
                count_q <= count_q + W'(1);
            end
        end
    end

    // Terminal-value flag
    always_comb begin
        last_o = (count_q == LAST);
    end

    assign count_o = count_q;

endmodule

// File: rtl/shs_fsm.sv
// Phase controller of the sequencer.
// It steps between waiting, real ramp, silent hiccup ramps and steady run.
// It also tells the two counters when to clear and when to step.
// Assumes trip pulses are already synchronous to clk.
module shs_fsm
    import shs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       pgood_i,
    input  logic       oc_trip_i,
    input  logic       ramp_last_i,
    input  logic       blank_last_i,
    output seq_state_t state_o,
    output logic       ramp_clear_o,
    output logic       ramp_step_o,
    output logic       blank_clear_o,
    output logic       blank_step_o
);

    seq_state_t st_q, st_d;

    // Next-phase and counter-control decision
    always_comb begin
        st_d          = st_q;
        ramp_clear_o  = 1'b0;
        ramp_step_o   = 1'b0;
        blank_clear_o = 1'b0;
        blank_step_o  = 1'b0;
        if (!(en_i && pgood_i)) begin
            st_d          = SEQ_IDLE;
            ramp_clear_o  = 1'b1;
            blank_clear_o = 1'b1;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    st_d          = SEQ_RAMP;
                    ramp_clear_o  = 1'b1;
                    blank_clear_o = 1'b1;
                end
                SEQ_RAMP: begin
                    if (oc_trip_i) begin
                        st_d          = SEQ_BLANK;
                        ramp_clear_o  = 1'b1;
                        blank_clear_o = 1'b1;
                    end else if (ramp_last_i) begin
                        st_d         = SEQ_RUN;
                        ramp_clear_o = 1'b1;
                    end else begin
                        ramp_step_o = 1'b1;
                    end
                end
                SEQ_RUN: begin
                    if (oc_trip_i) begin
                        st_d          = SEQ_BLANK;
                        ramp_clear_o  = 1'b1;
                        blank_clear_o = 1'b1;
                    end
                end
                SEQ_BLANK: begin
                    ramp_step_o = 1'b1;
                    if (ramp_last_i) begin
                        if (blank_last_i) begin
                            st_d          = SEQ_RAMP;
                            ramp_clear_o  = 1'b1;
                            blank_clear_o = 1'b1;
                        end else begin
                            blank_step_o = 1'b1;
                        end
                    end
                end
                default: begin
                    st_d          = SEQ_IDLE;
                    ramp_clear_o  = 1'b1;
                    blank_clear_o = 1'b1;
                end
            endcase
        end
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/shs_decode.sv
// Output decode of the sequencer.
// The code follows the ramp counter in a real ramp, is all ones in steady run
// and zero otherwise. Inhibit also reacts to a trip, a disable or a power loss
// in the same cycle. Assumes the state and the count are registered upstream.
module shs_decode
    import shs_pkg::*;
#(
    parameter int CODE_W = 11
) (
    input  seq_state_t        state_i,
    input  logic [CODE_W-1:0] ramp_cnt_i,
    input  logic              en_i,
    input  logic              pgood_i,
    input  logic              oc_trip_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              inhibit_o,
    output logic              done_o
);

    logic switching;

    // Reference code, done flag and gate inhibit
    always_comb begin
        switching = (state_i == SEQ_RAMP) || (state_i == SEQ_RUN);
        case (state_i)
            SEQ_RAMP: ref_code_o = ramp_cnt_i;
            SEQ_RUN:  ref_code_o = '1;
            default:  ref_code_o = '0;
        endcase
        done_o    = (state_i == SEQ_RUN);
        inhibit_o = !switching || oc_trip_i || !en_i || !pgood_i;
    end

endmodule

// File: rtl/softstart_hiccup_seq.sv
// Top of the soft-start and hiccup fault sequencer.
// A real ramp lasts 2**CODE_W clocks. After a trip, BLANK_RAMPS silent periods
// of the same length pass before a real ramp. Reset is synchronous, active low.
// Assumes all inputs are synchronous to clk.
module softstart_hiccup_seq
    import shs_pkg::*;
#(
    parameter int CODE_W      = 11,
    parameter int BLANK_RAMPS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              pgood_i,
    input  logic              oc_trip_i,
    output logic [CODE_W-1:0] ref_code_o,
    output logic              inhibit_o,
    output logic              done_o
);

    localparam int RAMP_LEN = 1 << CODE_W;
    localparam int BLANK_W  = (BLANK_RAMPS > 1) ? $clog2(BLANK_RAMPS) : 1;

    seq_state_t         seq_state;
    logic [CODE_W-1:0]  ramp_cnt;
    logic [BLANK_W-1:0] blank_cnt;
    logic               ramp_last, blank_last;
    logic               ramp_clear, ramp_step, blank_clear, blank_step;

    shs_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .pgood_i      (pgood_i),
        .oc_trip_i    (oc_trip_i),
        .ramp_last_i  (ramp_last),
        .blank_last_i (blank_last),
        .state_o      (seq_state),
        .ramp_clear_o (ramp_clear),
        .ramp_step_o  (ramp_step),
        .blank_clear_o(blank_clear),
        .blank_step_o (blank_step)
    );

    shs_counter #(.W(CODE_W), .LIMIT(RAMP_LEN)) u_ramp_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(ramp_clear),
        .step_i (ramp_step),
        .count_o(ramp_cnt),
        .last_o (ramp_last)
    );

    shs_counter #(.W(BLANK_W), .LIMIT(BLANK_RAMPS)) u_blank_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(blank_clear),
        .step_i (blank_step),
        .count_o(blank_cnt),
        .last_o (blank_last)
    );

    shs_decode #(.CODE_W(CODE_W)) u_decode (
        .state_i   (seq_state),
        .ramp_cnt_i(ramp_cnt),
        .en_i      (en_i),
        .pgood_i   (pgood_i),
        .oc_trip_i (oc_trip_i),
        .ref_code_o(ref_code_o),
        .inhibit_o (inhibit_o),
        .done_o    (done_o)
    );

    // blank_cnt is consumed only through blank_last
    logic unused_ok;
    assign unused_ok = ^blank_cnt;

endmodule

// File: rtl/shs_checker.sv
// Property checker for the sequencer, attached to the top by bind.
// It watches the ports and the phase register.
module shs_checker
    import shs_pkg::*;
#(
    parameter int CODE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              pgood_i,
    input logic              oc_trip_i,
    input logic [CODE_W-1:0] ref_code_o,
    input logic              inhibit_o,
    input logic              done_o,
    input seq_state_t        state_i
);

    localparam logic [CODE_W-1:0] FULL = '1;
    localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == SEQ_IDLE && !(en_i && pgood_i)) |=> (state_i == SEQ_IDLE));

    // R3
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit_o && !done_o && ref_code_o != FULL)
            |=> (inhibit_o || ref_code_o == $past(ref_code_o) + ONE));

    // R4
    done_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(ref_code_o) == FULL && !$past(inhibit_o)));

    // R5
    trip_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_trip_i && (state_i == SEQ_RAMP || state_i == SEQ_RUN))
            |=> (inhibit_o && !done_o && ref_code_o == '0));

    // R9
    off_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || !pgood_i) |-> inhibit_o);

    // R10
    off_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || !pgood_i) |=> (state_i == SEQ_IDLE && !done_o && ref_code_o == '0));

endmodule

bind softstart_hiccup_seq shs_checker #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .pgood_i   (pgood_i),
    .oc_trip_i (oc_trip_i),
    .ref_code_o(ref_code_o),
    .inhibit_o (inhibit_o),
    .done_o    (done_o),
    .state_i   (seq_state)
);

// File: tb/tb_softstart_hiccup_seq.sv
// Bench with a behavioural reference model that is compared on every clock.
module tb_softstart_hiccup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 11;
    localparam int RAMP_LEN   = 2048;
    localparam int SILENT_LEN = 3 * RAMP_LEN;

    logic clk = 1'b0;
    logic rst_n, en_i, pgood_i, oc_trip_i;
    logic [CODE_W-1:0] ref_code_o;
    logic inhibit_o, done_o;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";
    bit finished = 0;

    softstart_hiccup_seq dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .pgood_i(pgood_i),
        .oc_trip_i(oc_trip_i), .ref_code_o(ref_code_o),
        .inhibit_o(inhibit_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: phase 0 wait, 1 ramp, 2 silent, 3 steady
    int m_phase = 0;
    int m_elapsed = 0;

    task automatic expect_val(input string tag, input string what,
                              input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Model update at each edge, then output comparison a quarter period later
    always @(posedge clk) begin
        if (!rst_n || !(en_i && pgood_i)) begin
            m_phase = 0;
        end else if (m_phase == 0) begin
            m_phase = 1; m_elapsed = 0;
        end else if (m_phase == 1) begin
            if (oc_trip_i) begin m_phase = 2; m_elapsed = 0; end
            else if (m_elapsed == RAMP_LEN - 1) m_phase = 3;
            else m_elapsed++;
        end else if (m_phase == 3) begin
            if (oc_trip_i) begin m_phase = 2; m_elapsed = 0; end
        end else begin
            if (m_elapsed == SILENT_LEN - 1) begin m_phase = 1; m_elapsed = 0; end
            else m_elapsed++;
        end
        #(CLK_PERIOD/4);
        if (!finished) begin
            expect_val(cur_tag, "ref_code", int'(ref_code_o),
                       m_phase == 1 ? m_elapsed : (m_phase == 3 ? RAMP_LEN - 1 : 0));
            expect_val(cur_tag, "done", int'(done_o), m_phase == 3 ? 1 : 0);
            expect_val(cur_tag, "inhibit", int'(inhibit_o),
                       (m_phase == 1 || m_phase == 3) && !oc_trip_i && en_i && pgood_i ? 0 : 1);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trip_pulse();
        oc_trip_i = 1'b1;
        @(negedge clk);
        oc_trip_i = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; en_i = 1'b0; pgood_i = 1'b0; oc_trip_i = 1'b0;
        cur_tag = "R1";
        tick(4);
        rst_n = 1'b1;
        cur_tag = "R2";
        en_i = 1'b1;
        tick(40);
        en_i = 1'b0; pgood_i = 1'b1;
        tick(40);
        cur_tag = "R3";
        en_i = 1'b1;
        tick(2100);
        cur_tag = "R4";
        tick(200);
        cur_tag = "R5";
        oc_trip_i = 1'b1;
        #1 expect_val("R5", "inhibit same cycle", int'(inhibit_o), 1);
        @(negedge clk);
        oc_trip_i = 1'b0;
        cur_tag = "R7";
        tick(1000);
        trip_pulse();
        tick(3000);
        trip_pulse();
        cur_tag = "R6";
        tick(2500);
        cur_tag = "R8";
        trip_pulse();
        tick(SILENT_LEN + RAMP_LEN + 200);
        trip_pulse();
        tick(500);
        cur_tag = "R10";
        pgood_i = 1'b0;
        #1 expect_val("R10", "inhibit same cycle", int'(inhibit_o), 1);
        tick(5);
        pgood_i = 1'b1;
        tick(700);
        cur_tag = "R9";
        en_i = 1'b0;
        #1 expect_val("R9", "inhibit same cycle", int'(inhibit_o), 1);
        tick(10);
        en_i = 1'b1;
        tick(2200);
        cur_tag = "R10";
        pgood_i = 1'b0;
        tick(10);
        finish_run();
    end

endmodule